// File: doc/BRIEF.md
# I2C Slave Bus Engine

This block is the bit-level half of an I2C slave. It watches the open-drain SCL and SDA lines through a two-flop synchroniser and detects start, repeated start and stop conditions. It shifts address and data bytes in and out, and it recognises its own 7-bit address, a 10-bit address made of a header byte plus a second byte, or the general call address. It drives the acknowledge bit and stretches SCL whenever an event waits for software. The master sets the bus speed. The engine never acts as a master.

The block talks to a separate status unit through event pulses and a byte-wide data port. For received data, the status unit reads `rx_data` and then pulses `ev_release`. For transmitted data, it places the next byte on `tx_data` and pulses `tx_write`. SCL stays low until that service happens, so a slow controller slows the bus down and never loses data.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset, both line drivers are off, all event pulses are low and `is_tx` is 0.
- R2: With `ten_bit_en`=0, an address byte whose upper seven bits equal `own_addr[6:0]` and whose LSB (R/W) is 0 is acknowledged on the ninth clock, raises `ev_addr` with `is_tx`=0, and SCL is then held low until `ev_release` is pulsed.
- R3: An address that matches nothing gets no acknowledge and raises no event. The engine then ignores all bytes until the next start or stop, and that stop raises no `ev_stop`.
- R4: The byte 0x00 is matched as a general call (receive) only while `gc_en` is 1. Otherwise it is not acknowledged.
- R5: When `ack_en` is 0, SDA stays released on the ninth clock of a matched address or received byte. The event is still raised.
- R6: In receive mode, each byte is taken MSB first into `rx_data`, acknowledged when `ack_en`=1, and signalled by `ev_byte`. SCL is then held low until `ev_release`.
- R7: An address whose R/W bit is 1 sets `is_tx`=1. SCL is held low until `tx_write`, and the byte then written on `tx_data` is shifted onto SDA MSB first.
- R8: In transmit mode, a master ACK (SDA low on the ninth clock) raises `ev_byte` and stretches SCL until the next `tx_write`. A NACK raises `ev_nack` and leaves SDA and SCL released.
- R9: With `ten_bit_en`=1, the header 11110, `addr_hi[1:0]`, 0 (MSB first) is acknowledged without an event. A following byte equal to `own_addr` completes the match with `ev_addr`. A header with other high bits, or a second byte that differs, is not acknowledged.
- R10: A 10-bit header with R/W=1 is accepted, with `is_tx`=1, only after a repeated start that follows a complete 10-bit match. After a stop, the same header is not acknowledged.
- R11: A stop raises `ev_stop` when the engine was addressed since the last start, and the engine returns to idle with both drivers off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr | input | 8 | Own address: bits 6:0 in 7-bit mode, all 8 bits as the low byte in 10-bit mode |
| addr_hi | input | 2 | Address bits 9:8 in 10-bit mode |
| ten_bit_en | input | 1 | Select 10-bit addressing |
| gc_en | input | 1 | Accept the general call address |
| ack_en | input | 1 | Acknowledge matched addresses and received bytes |
| rx_data | output | 8 | Last received data byte |
| tx_data | input | 8 | Next byte to transmit |
| tx_write | input | 1 | Pulse: `tx_data` is valid, end the transmit stretch |
| ev_release | input | 1 | Pulse: receive event serviced, end the stretch |
| ev_addr | output | 1 | Pulse: address matched |
| ev_byte | output | 1 | Pulse: byte received, or transmitted byte acknowledged |
| ev_nack | output | 1 | Pulse: master did not acknowledge a transmitted byte |
| ev_stop | output | 1 | Pulse: stop seen while addressed |
| is_tx | output | 1 | Engine is transmitter for the current transfer |

## Verification
The bench drives the bus with several address patterns: a matching 7-bit address for write and for read, a neighbouring address one bit away, 0x00 with general call enabled and disabled, and 10-bit headers whose high bits are right or wrong, whose second byte is right or wrong, and whose read form arrives with or without a prior full match. Each pattern separates a matching rule from its near miss. Data bytes with alternating, unbalanced and edge bit values (0xA5, 0x96, 0x81, 0x0F) expose errors in bit order or shifting. A transmitted byte closed by a master ACK is compared with one closed by a NACK, which separates the continue path from the abort path. Runs with `ack_en` high and low separate the acknowledge drive from event generation.

// File: rtl/i2c_slave_engine.sv
`timescale 1ns/1ps
module i2c_slave_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic [7:0] own_addr,
  input  logic [1:0] addr_hi,
  input  logic       ten_bit_en,
  input  logic       gc_en,
  input  logic       ack_en,
  output logic [7:0] rx_data,
  input  logic [7:0] tx_data,
  input  logic       tx_write,
  input  logic       ev_release,
  output logic       ev_addr,
  output logic       ev_byte,
  output logic       ev_nack,
  output logic       ev_stop,
  output logic       is_tx
);
  typedef enum logic [3:0] {S_IDLE, S_ADDR, S_ADDR2, S_ACK, S_HOLD,
                            S_RX, S_TX, S_MACK, S_SKIP} st_t;

  st_t        st, after_ack;
  logic [2:0] scl_p, sda_p;
  logic [7:0] sr;
  logic [3:0] cnt;
  logic [1:0] post_ev;
  logic       ack_q, ten_ok, sel, mack_n;

  wire scl_s = scl_p[1], scl_q = scl_p[2];
  wire sda_s = sda_p[1], sda_q = sda_p[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_end = scl_fall && cnt == 4'd8;

  wire hdr = ten_bit_en && sr[7:3] == 5'b11110 && sr[2:1] == addr_hi;
  wire m7  = !ten_bit_en && sr[7:1] == own_addr[6:0];
  wire mgc = gc_en && sr == 8'h00;

  assign scl_drive_low = (st == S_HOLD);
  assign sda_drive_low = (st == S_ACK && ack_q) || (st == S_TX && !sr[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111; sda_p <= 3'b111;
      st <= S_IDLE; after_ack <= S_IDLE; post_ev <= 2'd0;
      sr <= 8'h00; cnt <= 4'd0; rx_data <= 8'h00;
      ack_q <= 1'b0; ten_ok <= 1'b0; sel <= 1'b0; mack_n <= 1'b0; is_tx <= 1'b0;
      ev_addr <= 1'b0; ev_byte <= 1'b0; ev_nack <= 1'b0; ev_stop <= 1'b0;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      ev_addr <= 1'b0; ev_byte <= 1'b0; ev_nack <= 1'b0; ev_stop <= 1'b0;
      if (stop_c) begin
        ev_stop <= sel; sel <= 1'b0; ten_ok <= 1'b0; is_tx <= 1'b0; st <= S_IDLE;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= 4'd0; sel <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_ADDR2, S_RX: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              ack_q <= ack_en;
              if (st == S_RX) begin
                rx_data <= sr; st <= S_ACK; after_ack <= S_HOLD; post_ev <= 2'd2;
              end else if (st == S_ADDR2) begin
                if (sr == own_addr) begin
                  ten_ok <= 1'b1; is_tx <= 1'b0; sel <= 1'b1;
                  st <= S_ACK; after_ack <= S_HOLD; post_ev <= 2'd1;
                end else begin
                  ten_ok <= 1'b0; st <= S_SKIP;
                end
              end else if (hdr && !sr[0]) begin
                st <= S_ACK; after_ack <= S_ADDR2; post_ev <= 2'd0;
              end else if ((hdr && ten_ok) || m7 || mgc) begin
                is_tx <= sr[0]; sel <= 1'b1;
                st <= S_ACK; after_ack <= S_HOLD; post_ev <= 2'd1;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            st <= after_ack; cnt <= 4'd0;
            ev_addr <= (post_ev == 2'd1);
            ev_byte <= (post_ev == 2'd2);
          end
          S_HOLD: begin
            if (is_tx && tx_write) begin
              sr <= tx_data; cnt <= 4'd0; st <= S_TX;
            end else if (!is_tx && ev_release) begin
              cnt <= 4'd0; st <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) st <= S_MACK;
            else begin
              sr <= {sr[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) mack_n <= sda_s;
            else if (scl_fall) begin
              if (mack_n) begin ev_nack <= 1'b1; st <= S_SKIP; end
              else begin ev_byte <= 1'b1; st <= S_HOLD; end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slave_engine_chk.sv
`timescale 1ns/1ps
module i2c_slave_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic tx_write,
  input logic ev_release,
  input logic ev_addr,
  input logic ev_byte,
  input logic ev_nack,
  input logic ev_stop
);
  a_r1_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_addr, ev_byte, ev_nack, ev_stop}));
  a_r2_stretch_on_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |-> scl_drive_low);
  a_r6_stretch_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |-> scl_drive_low);
  a_r2_hold_until_serviced: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !ev_release && !tx_write) |=> scl_drive_low);
  a_r8_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |-> (!sda_drive_low && !scl_drive_low));
  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> (!sda_drive_low && !scl_drive_low));
endmodule

bind i2c_slave_engine i2c_slave_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .tx_write(tx_write), .ev_release(ev_release), .ev_addr(ev_addr), .ev_byte(ev_byte),
  .ev_nack(ev_nack), .ev_stop(ev_stop)
);

// File: tb/i2c_slave_engine_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_engine_tb_top;
  localparam int HP = 20;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, ten_bit_en, gc_en, ack_en, tx_write, ev_release;
  logic [7:0] own_addr, tx_data;
  logic [1:0] addr_hi;
  logic scl_dl, sda_dl, ev_addr, ev_byte, ev_nack, ev_stop, is_tx;
  logic [7:0] rx_data;
  wire scl_ln = scl_m & ~scl_dl;
  wire sda_ln = sda_m & ~sda_dl;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  i2c_slave_engine dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .own_addr(own_addr),
    .addr_hi(addr_hi), .ten_bit_en(ten_bit_en), .gc_en(gc_en), .ack_en(ack_en),
    .rx_data(rx_data), .tx_data(tx_data), .tx_write(tx_write), .ev_release(ev_release),
    .ev_addr(ev_addr), .ev_byte(ev_byte), .ev_nack(ev_nack), .ev_stop(ev_stop),
    .is_tx(is_tx));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // event codes: kind*256+data; 1 addr (data=is_tx), 2 byte (rx data or 0 in tx), 3 nack, 4 stop
  task automatic expect_ev(int kind, int data, string tag);
    exp_q.push_back(kind * 256 + data);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (ev_addr || ev_byte || ev_nack || ev_stop)) begin
      int code;
      code = ev_addr ? 256 + int'(is_tx) :
             ev_byte ? 512 + (is_tx ? 0 : int'(rx_data)) :
             ev_nack ? 768 : 1024;
      if (exp_q.size() == 0) chk(1'b0, "unexpected event (R3)", code, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(code == e, t, code, e);
      end
    end
  end

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic scl_up();
    scl_m = 1'b1;
    clks(1);
    while (!scl_ln) clks(1);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; clks(HP/2); scl_up(); clks(HP/2);
    sda_m = 1'b0; clks(HP/2); scl_m = 1'b0; clks(HP/2);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; clks(HP/2); scl_up(); clks(HP/2);
    sda_m = 1'b1; clks(HP);
  endtask
  task automatic send_bit(bit b);
    sda_m = b; clks(HP/2); scl_up(); clks(HP); scl_m = 1'b0; clks(HP/2);
  endtask
  task automatic read_bit(output bit b);
    sda_m = 1'b1; clks(HP/2); scl_up(); clks(HP/2);
    b = sda_ln; clks(HP/2); scl_m = 1'b0; clks(HP/2);
  endtask
  task automatic wr_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(b);
    ack = !b;
  endtask
  task automatic rd_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); d[i] = b; end
    send_bit(!give_ack);
  endtask
  task automatic release_rx(string tag);
    chk(scl_dl == 1'b1, tag, int'(scl_dl), 1);
    ev_release = 1'b1; clks(1); ev_release = 1'b0; clks(2);
  endtask
  task automatic load_tx(logic [7:0] d);
    tx_data = d; tx_write = 1'b1; clks(1); tx_write = 1'b0; clks(2);
  endtask
  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; own_addr = 8'h2A; addr_hi = 2'b00;
    ten_bit_en = 1'b0; gc_en = 1'b0; ack_en = 1'b1; tx_data = 8'h00;
    tx_write = 1'b0; ev_release = 1'b0;
    clks(5); rst_n = 1'b1; clks(5);
    chk(scl_dl == 1'b0 && sda_dl == 1'b0, "R1 drivers off", int'({scl_dl, sda_dl}), 0);
    chk(is_tx == 1'b0, "R1 is_tx", int'(is_tx), 0);

    // 7-bit write
    bus_start();
    expect_ev(1, 0, "R2 addr event");
    wr_byte(8'h54, ack);
    chk(ack, "R2 address ack", int'(ack), 1);
    chk(is_tx == 1'b0, "R2 is_tx", int'(is_tx), 0);
    clks(40);
    release_rx("R2 stretch held");
    expect_ev(2, 8'hA5, "R6 rx byte");
    wr_byte(8'hA5, ack);
    chk(ack, "R6 data ack", int'(ack), 1);
    release_rx("R6 stretch held");
    ack_en = 1'b0;
    expect_ev(2, 8'h3C, "R5 rx byte without ack");
    wr_byte(8'h3C, ack);
    chk(!ack, "R5 no ack", int'(ack), 0);
    release_rx("R5 stretch held");
    ack_en = 1'b1;
    expect_ev(4, 0, "R11 stop event");
    bus_stop();
    chk(scl_dl == 1'b0 && sda_dl == 1'b0, "R11 idle drivers", int'({scl_dl, sda_dl}), 0);

    // mismatch
    bus_start();
    wr_byte(8'h56, ack);
    chk(!ack, "R3 mismatch no ack", int'(ack), 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R3 byte ignored", int'(ack), 0);
    chk(scl_dl == 1'b0, "R3 no stretch", int'(scl_dl), 0);
    bus_stop();

    // general call
    bus_start();
    wr_byte(8'h00, ack);
    chk(!ack, "R4 general call disabled", int'(ack), 0);
    bus_stop();
    gc_en = 1'b1;
    bus_start();
    expect_ev(1, 0, "R4 general call event");
    wr_byte(8'h00, ack);
    chk(ack, "R4 general call ack", int'(ack), 1);
    release_rx("R4 stretch held");
    expect_ev(4, 0, "R11 stop after general call");
    bus_stop();
    gc_en = 1'b0;

    // 7-bit read
    bus_start();
    expect_ev(1, 1, "R7 read addr event");
    wr_byte(8'h55, ack);
    chk(ack, "R7 read addr ack", int'(ack), 1);
    chk(is_tx == 1'b1, "R7 is_tx", int'(is_tx), 1);
    clks(60);
    chk(scl_dl == 1'b1, "R7 stretch until write", int'(scl_dl), 1);
    load_tx(8'h96);
    expect_ev(2, 0, "R8 master ack event");
    rd_byte(d, 1'b1);
    chk(d == 8'h96, "R7 tx byte", int'(d), 'h96);
    chk(scl_dl == 1'b1, "R8 stretch after ack", int'(scl_dl), 1);
    load_tx(8'h0F);
    expect_ev(3, 0, "R8 nack event");
    rd_byte(d, 1'b0);
    chk(d == 8'h0F, "R7 second tx byte", int'(d), 'h0F);
    chk(sda_dl == 1'b0 && scl_dl == 1'b0, "R8 released after nack", int'({scl_dl, sda_dl}), 0);
    expect_ev(4, 0, "R11 stop after read");
    bus_stop();

    // 10-bit
    ten_bit_en = 1'b1; addr_hi = 2'b10; own_addr = 8'h5A;
    bus_start();
    wr_byte(8'hF4, ack);
    chk(ack, "R9 header ack", int'(ack), 1);
    expect_ev(1, 0, "R9 full match event");
    wr_byte(8'h5A, ack);
    chk(ack, "R9 second byte ack", int'(ack), 1);
    release_rx("R9 stretch held");
    expect_ev(2, 8'h33, "R9 rx byte");
    wr_byte(8'h33, ack);
    release_rx("R9 data stretch");
    bus_start();
    expect_ev(1, 1, "R10 read header event");
    wr_byte(8'hF5, ack);
    chk(ack, "R10 read header ack", int'(ack), 1);
    chk(is_tx == 1'b1, "R10 is_tx", int'(is_tx), 1);
    load_tx(8'hC3);
    expect_ev(2, 0, "R10 master ack event");
    rd_byte(d, 1'b1);
    chk(d == 8'hC3, "R10 tx byte", int'(d), 'hC3);
    load_tx(8'h81);
    expect_ev(3, 0, "R10 nack event");
    rd_byte(d, 1'b0);
    chk(d == 8'h81, "R10 second tx byte", int'(d), 'h81);
    expect_ev(4, 0, "R11 stop after 10-bit");
    bus_stop();

    bus_start();
    wr_byte(8'hF5, ack);
    chk(!ack, "R10 read header without match", int'(ack), 0);
    bus_stop();
    bus_start();
    wr_byte(8'hF0, ack);
    chk(!ack, "R9 wrong high bits", int'(ack), 0);
    bus_stop();
    bus_start();
    wr_byte(8'hF4, ack);
    chk(ack, "R9 header ack again", int'(ack), 1);
    wr_byte(8'h11, ack);
    chk(!ack, "R9 wrong second byte", int'(ack), 0);
    bus_stop();

    clks(20);
    chk(exp_q.size() == 0, "R11 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule